// File: doc/BRIEF.md
# Current-Source Buck-Boost Inverter Gate Sequencer

This block drives the seven switches of a single-stage, current-source buck-boost inverter. The seven switches are one dc-link charging switch, three upper bridge switches and three lower bridge switches. Each carrier period is a fixed number of clock cycles. At the first cycle of a period the block takes a charging duty ratio and three signed phase modulation values. It converts them into per-switch on-times, measured in cycles, and keeps them for the whole period.

Each period opens with the charging switch on while the whole bridge is held off. For the rest of the period the charging switch is off. One upper switch and one lower switch then conduct at every cycle, one after another in a fixed phase order. The on-time of each bridge switch is the positive part of its phase value (upper group) or the negative part (lower group), plus a common zero-sequence offset. The offset spreads the unused time evenly over the three phases. If the inputs would need a modulation index at or above the off-interval fraction, the block raises a limit flag. It then runs a safe pattern instead.

The sequencer has three states. In `ST_RESET`, all gates are held low while reset is high. In `ST_CHARGE`, the charging switch is on. In `ST_BRIDGE`, the bridge conducts. There are four transitions:
- **release**: on the first clock edge after reset is released, the state goes from `ST_RESET` to `ST_CHARGE`, or to `ST_BRIDGE` when the charge count is zero.
- **charge end**: from `ST_CHARGE` to `ST_BRIDGE` when the charge count is used up.
- **wrap**: on the last cycle of a period, the state goes to `ST_CHARGE` or to `ST_BRIDGE` for the next period. The new inputs are loaded at the same edge.
- **reset**: from any state to `ST_RESET` while reset is high.

Top module: `cbb_pwm_seq`

## Requirements
- R1: Reset is synchronous and active high. One cycle after a clock edge with reset high, all seven gates are low. The first period starts at the first clock edge with reset low, so its cycle 0 is the cycle that follows that edge.
- R2: In each period, `gate_dc_o` is high for the first C cycles and low for the rest, where C = floor(D·P/32768). D is the clamped duty (Q1.15, 32768 = 1.0) and P is `PERIOD`. While `gate_dc_o` is high, all six bridge gates are low.
- R3: In each of the remaining P−C cycles, `gate_dc_o` is low. Exactly one bit of `gate_up_o` is high and exactly one bit of `gate_lo_o` is high.
- R4: Bit 0 is phase a, bit 1 is phase b and bit 2 is phase c. Within the bridge interval the upper group runs a, b, c back to back, and so does the lower group. Each gate is high for its count. A gate whose count is zero is never high in that period.
- R5: The offset is z = floor((32768 − D − M)/3), where M is the largest of the magnitudes of the three phase values. The phase-a and phase-b upper counts are floor((max(m,0)+z)·P/32768). The lower counts use max(−m,0) in place of max(m,0). The phase-c count of each group is P−C minus the other two counts.
- R6: `limit_err_o` is high for the period when D > 32768, or when M ≥ 32768 − D. In that period D is clamped to 32768 and all three phase values are treated as zero.
- R7: The inputs are sampled only at the edge that starts a period. Changes at other times do not affect the gates or the flag until the next period.
- R8: The phase-a count of a group is capped at P−C. If the phase-a and phase-b counts together exceed P−C, the phase-b count is reduced to fill P−C exactly, and the phase-c count becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_dc_i | input | 16 | Charging duty ratio, unsigned Q1.15 |
| mod_a_i | input | 16 | Phase-a modulation value, signed Q1.15 |
| mod_b_i | input | 16 | Phase-b modulation value, signed Q1.15 |
| mod_c_i | input | 16 | Phase-c modulation value, signed Q1.15 |
| gate_dc_o | output | 1 | Charging switch gate |
| gate_up_o | output | 3 | Upper bridge gates, bit 0 = a, 1 = b, 2 = c |
| gate_lo_o | output | 3 | Lower bridge gates, bit 0 = a, 1 = b, 2 = c |
| limit_err_o | output | 1 | Modulation limit flag for the current period |

## Verification
The bench compares every cycle of several periods against a model built from the requirements.

It covers these corner cases:
- **Zero charge time.** The period starts directly in the bridge state. A design that always enters `ST_CHARGE` would hold the charging switch on for one extra cycle.
- **Zero offset with phases of zero count.** A design that does not skip zero-count phases would raise a gate for one stray cycle, or drive two gates at once in one group.
- **Over-limit inputs, including a duty above 1.0.** A design that does not fall back to the safe pattern would produce gate counts built from a negative offset.
- **Unbalanced phase values that overfill the upper group.** Without the cap of R8, the phase-c count would wrap around and the design would lose the one-hot pattern.
- **An input change in mid-period.** A design that samples its inputs continuously would change the gates part way through the period.

// File: rtl/cbb_pwm_pkg.sv
`timescale 1ns/1ps
package cbb_pwm_pkg;
    // Q1.15 fixed point: FRAC fractional bits, Q_ONE represents 1.0
    localparam int QW    = 16;
    localparam int FRAC  = 15;
    localparam int Q_ONE = 1 << FRAC;

    typedef enum logic [1:0] {
        ST_RESET,
        ST_CHARGE,
        ST_BRIDGE
    } seq_state_e;
endpackage

// File: rtl/cbb_duty_calc.sv
`timescale 1ns/1ps
// Turns one input set into cycle counts for the charge interval and both bridge groups.
module cbb_duty_calc
    import cbb_pwm_pkg::*;
#(
    parameter int PERIOD = 15000,
    parameter int CW     = $clog2(PERIOD + 1)
) (
    input  logic [QW-1:0]        ddc_i,
    input  logic [QW-1:0]        mod_i [3],
    output logic [CW-1:0]        dc_cnt_o,
    output logic [2:0][CW-1:0]   up_len_o,
    output logic [2:0][CW-1:0]   lo_len_o,
    output logic                 err_o
);
    localparam int AW = QW + 1;
    localparam int DW = QW + 2;
    localparam int PW = DW + CW;
    localparam logic [AW-1:0] ONE = AW'(Q_ONE);

    logic [AW-1:0] ext   [3];
    logic [AW-1:0] mag   [3];
    logic [AW-1:0] max_mag;
    logic [AW-1:0] ddc_eff;
    logic [AW-1:0] rem;
    logic [AW-1:0] max_eff;
    logic [AW-1:0] zero_seq;
    logic [CW-1:0] off_cnt;
    logic [1:0][CW-1:0] up_raw;
    logic [1:0][CW-1:0] lo_raw;

    function automatic logic [CW-1:0] to_cycles(input logic [DW-1:0] q);
        logic [PW-1:0] prod;
        prod = PW'(q) * PW'(PERIOD);
        return CW'(prod >> FRAC);
    endfunction

    function automatic logic [2:0][CW-1:0] fill_group(input logic [CW-1:0] l0,
                                                      input logic [CW-1:0] l1,
                                                      input logic [CW-1:0] span);
        logic [CW-1:0] a;
        logic [CW-1:0] b;
        logic [CW-1:0] rest;
        a    = (l0 > span) ? span : l0;
        rest = span - a;
        b    = (l1 > rest) ? rest : l1;
        return {rest - b, b, a};
    endfunction

    // Magnitudes of all three phases, 17 bits so that -1.0 is representable.
    for (genvar i = 0; i < 3; i++) begin : g_mag
        assign ext[i] = {mod_i[i][QW-1], mod_i[i]};
        assign mag[i] = mod_i[i][QW-1] ? (~ext[i] + AW'(1)) : ext[i];
    end

    always_comb begin
        max_mag = mag[0];
        if (mag[1] > max_mag) max_mag = mag[1];
        if (mag[2] > max_mag) max_mag = mag[2];
    end

    always_comb begin
        ddc_eff  = ({1'b0, ddc_i} > ONE) ? ONE : {1'b0, ddc_i};
        rem      = ONE - ddc_eff;
        err_o    = ({1'b0, ddc_i} > ONE) || (max_mag >= rem);
        max_eff  = err_o ? '0 : max_mag;
        zero_seq = (rem - max_eff) / AW'(3);
        dc_cnt_o = to_cycles(DW'(ddc_eff));
        off_cnt  = CW'(PERIOD) - dc_cnt_o;
    end

    // Only phases a and b are scaled; phase c takes the residue of each group.
    for (genvar i = 0; i < 2; i++) begin : g_scale
        logic [AW-1:0] pos_part;
        logic [AW-1:0] neg_part;
        always_comb begin
            pos_part = (err_o || mod_i[i][QW-1]) ? '0 : ext[i];
            neg_part = (err_o || !mod_i[i][QW-1]) ? '0 : mag[i];
        end
        assign up_raw[i] = to_cycles(DW'(pos_part) + DW'(zero_seq));
        assign lo_raw[i] = to_cycles(DW'(neg_part) + DW'(zero_seq));
    end

    assign up_len_o = fill_group(up_raw[0], up_raw[1], off_cnt);
    assign lo_len_o = fill_group(lo_raw[0], lo_raw[1], off_cnt);
endmodule

// File: rtl/cbb_group_seq.sv
`timescale 1ns/1ps
// Picks the conducting switch of one bridge group from the offset into the bridge interval.
module cbb_group_seq #(
    parameter int CW = 14
) (
    input  logic                en_i,
    input  logic [CW-1:0]       t_i,
    input  logic [2:0][CW-1:0]  len_i,
    output logic [2:0]          sel_o
);
    logic [CW:0] bound [3];

    for (genvar i = 0; i < 3; i++) begin : g_slot
        logic [CW:0] lo_edge;
        if (i == 0) begin : g_first
            assign bound[i] = {1'b0, len_i[i]};
            assign lo_edge  = '0;
        end else begin : g_next
            assign bound[i] = bound[i-1] + {1'b0, len_i[i]};
            assign lo_edge  = bound[i-1];
        end
        assign sel_o[i] = en_i && ({1'b0, t_i} >= lo_edge) && ({1'b0, t_i} < bound[i]);
    end
endmodule

// File: rtl/cbb_pwm_seq.sv
`timescale 1ns/1ps
module cbb_pwm_seq
    import cbb_pwm_pkg::*;
#(
    parameter int PERIOD = 15000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [15:0]           duty_dc_i,
    input  logic signed [15:0]    mod_a_i,
    input  logic signed [15:0]    mod_b_i,
    input  logic signed [15:0]    mod_c_i,
    output logic                  gate_dc_o,
    output logic [2:0]            gate_up_o,
    output logic [2:0]            gate_lo_o,
    output logic                  limit_err_o
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    seq_state_e          state_q, state_d;
    logic [CW-1:0]       cnt_q;
    logic [CW-1:0]       dc_q;
    logic [2:0][CW-1:0]  up_q, lo_q;
    logic                err_q;

    logic [QW-1:0]       mod_arr [3];
    logic [CW-1:0]       dc_new;
    logic [2:0][CW-1:0]  up_new, lo_new;
    logic                err_new;
    logic                wrap;
    logic                bridge_en;
    logic [CW-1:0]       t_off;

    assign mod_arr[0] = mod_a_i;
    assign mod_arr[1] = mod_b_i;
    assign mod_arr[2] = mod_c_i;

    cbb_duty_calc #(.PERIOD(PERIOD), .CW(CW)) u_calc (
        .ddc_i    (duty_dc_i),
        .mod_i    (mod_arr),
        .dc_cnt_o (dc_new),
        .up_len_o (up_new),
        .lo_len_o (lo_new),
        .err_o    (err_new)
    );

    assign wrap = (state_q == ST_RESET) || (cnt_q == LAST);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:  state_d = (dc_new != '0) ? ST_CHARGE : ST_BRIDGE;
            ST_CHARGE: begin
                if (wrap)
                    state_d = (dc_new != '0) ? ST_CHARGE : ST_BRIDGE;
                else if ((cnt_q + CW'(1)) == dc_q)
                    state_d = ST_BRIDGE;
            end
            ST_BRIDGE: begin
                if (wrap)
                    state_d = (dc_new != '0) ? ST_CHARGE : ST_BRIDGE;
            end
            default:   state_d = ST_RESET;
        endcase
    end

    // State, counter and per-period parameter registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RESET;
            cnt_q   <= '0;
            dc_q    <= '0;
            up_q    <= '0;
            lo_q    <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (wrap) begin
                cnt_q <= '0;
                dc_q  <= dc_new;
                up_q  <= up_new;
                lo_q  <= lo_new;
                err_q <= err_new;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        gate_dc_o   = (state_q == ST_CHARGE);
        bridge_en   = (state_q == ST_BRIDGE);
        t_off       = cnt_q - dc_q;
        limit_err_o = err_q;
    end

    cbb_group_seq #(.CW(CW)) u_upper (
        .en_i  (bridge_en),
        .t_i   (t_off),
        .len_i (up_q),
        .sel_o (gate_up_o)
    );

    cbb_group_seq #(.CW(CW)) u_lower (
        .en_i  (bridge_en),
        .t_i   (t_off),
        .len_i (lo_q),
        .sel_o (gate_lo_o)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!gate_dc_o && gate_up_o == 3'b000 && gate_lo_o == 3'b000));

    assert_charge_leads_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_RESET && !gate_dc_o && cnt_q != LAST) |=> !gate_dc_o);

    assert_up_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BRIDGE) |-> ($countones(gate_up_o) == 1 && !gate_dc_o));

    assert_lo_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BRIDGE) |-> ($countones(gate_lo_o) == 1 && !gate_dc_o));

    assert_hold_params_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_RESET && cnt_q != LAST) |=>
        ($stable(dc_q) && $stable(up_q) && $stable(lo_q) && $stable(err_q)));
endmodule

// File: tb/cbb_pwm_seq_bench.sv
`timescale 1ns/1ps
module cbb_pwm_seq_bench;
    localparam int P = 200;

    logic               clk = 1'b0;
    logic               rst;
    logic [15:0]        ddc;
    logic signed [15:0] ma, mb, mc;
    logic               gate_dc;
    logic [2:0]         gate_up, gate_lo;
    logic               lim;

    always #4 clk = ~clk;

    cbb_pwm_seq #(.PERIOD(P)) u_cbb_pwm_seq (
        .clk         (clk),
        .rst         (rst),
        .duty_dc_i   (ddc),
        .mod_a_i     (ma),
        .mod_b_i     (mb),
        .mod_c_i     (mc),
        .gate_dc_o   (gate_dc),
        .gate_up_o   (gate_up),
        .gate_lo_o   (gate_lo),
        .limit_err_o (lim)
    );

    typedef struct {
        logic [7:0] v;
        string      tag;
        int         cyc;
    } item_t;

    item_t q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic int fill_cap(input int raw, input int span);
        return (raw > span) ? span : raw;
    endfunction

    // Expected counts derived from R2, R5, R6 and R8
    task automatic model(input int d, input int a, input int b, input int c,
                         output int cdc, output int up[3], output int lo[3], output bit err);
        int m[3];
        int deff, rem, mx, z, off, r;
        m[0] = a; m[1] = b; m[2] = c;
        deff = (d > 32768) ? 32768 : d;
        rem  = 32768 - deff;
        mx   = 0;
        for (int i = 0; i < 3; i++) begin
            int av;
            av = (m[i] < 0) ? -m[i] : m[i];
            if (av > mx) mx = av;
        end
        err = (d > 32768) || (mx >= rem);
        if (err) begin
            m[0] = 0; m[1] = 0; m[2] = 0; mx = 0;
        end
        z   = (rem - mx) / 3;
        cdc = deff * P / 32768;
        off = P - cdc;
        up[0] = fill_cap(((m[0] > 0 ? m[0] : 0) + z) * P / 32768, off);
        r     = off - up[0];
        up[1] = fill_cap(((m[1] > 0 ? m[1] : 0) + z) * P / 32768, r);
        up[2] = r - up[1];
        lo[0] = fill_cap(((m[0] < 0 ? -m[0] : 0) + z) * P / 32768, off);
        r     = off - lo[0];
        lo[1] = fill_cap(((m[1] < 0 ? -m[1] : 0) + z) * P / 32768, r);
        lo[2] = r - lo[1];
    endtask

    function automatic logic [2:0] pick(input int t, input int len[3]);
        if (t < len[0]) return 3'b001;
        if (t < len[0] + len[1]) return 3'b010;
        return 3'b100;
    endfunction

    // Driver: called at the falling edge before the edge that starts the period
    task automatic run_period(input int d, input int a, input int b, input int c,
                              input string tag, input bit disturb);
        int cdc;
        int up[3];
        int lo[3];
        bit err;
        model(d, a, b, c, cdc, up, lo, err);
        ddc = 16'(d); ma = 16'(a); mb = 16'(b); mc = 16'(c);
        for (int j = 0; j < P; j++) begin
            item_t it;
            if (j < cdc)
                it.v = {err, 1'b1, 6'b000000};
            else
                it.v = {err, 1'b0, pick(j - cdc, lo), pick(j - cdc, up)};
            it.tag = tag;
            it.cyc = j;
            q.push_back(it);
        end
        for (int k = 0; k < P; k++) begin
            @(negedge clk);
            if (disturb && k == P / 2) begin
                ddc = 16'h0400; ma = 16'sh2000; mb = -16'sh2000; mc = 16'sh0000;
            end
        end
    endtask

    // Monitor: compares each cycle well after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it  = q.pop_front();
                got = {lim, gate_dc, gate_lo, gate_up};
                check(got === it.v, $sformatf("%s cycle %0d", it.tag, it.cyc), got, it.v);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        ddc = '0; ma = '0; mb = '0; mc = '0;
        repeat (3) @(negedge clk);
        check({gate_dc, gate_lo, gate_up} === 7'd0, "R1 reset state",
              {1'b0, gate_dc, gate_lo, gate_up}, 8'd0);
        check(lim === 1'b0, "R1 reset flag", {7'd0, lim}, 8'd0);
        rst = 1'b0;
        // balanced set: charge then bridge (R2 R3 R5)
        run_period(8192, 16384, -8192, -8192, "R2 R3 R5 balanced", 1'b0);
        // zero charge duty, all phases zero (R2 R5)
        run_period(0, 0, 0, 0, "R2 R5 zero charge", 1'b0);
        // negative-heavy phase a (R4 R5)
        run_period(6554, -19661, 9830, 9830, "R4 R5 negative lead", 1'b0);
        // zero offset, phases with zero count skipped (R4)
        run_period(16384, 16382, -8191, -8191, "R4 zero count skip", 1'b0);
        // over limit modulation (R6)
        run_period(16384, 29491, -14746, -14745, "R6 over limit", 1'b0);
        // duty above one (R6)
        run_period(40000, 1000, -500, -500, "R6 duty above one", 1'b0);
        // mid-period change ignored (R7)
        run_period(9830, -8000, 16000, -8000, "R7 mid change", 1'b1);
        run_period(9830, -8000, 16000, -8000, "R7 after change", 1'b0);
        // unbalanced set overfilling the upper group (R8)
        run_period(0, 14746, 14746, 0, "R8 saturate", 1'b0);
        // reset in operation (R1)
        rst = 1'b1;
        @(negedge clk);
        check({gate_dc, gate_lo, gate_up} === 7'd0, "R1 reset in run",
              {1'b0, gate_dc, gate_lo, gate_up}, 8'd0);
        repeat (3) @(negedge clk);
        check({lim, gate_dc, gate_lo, gate_up} === 8'd0, "R1 reset held",
              {lim, gate_dc, gate_lo, gate_up}, 8'd0);
        done = 1'b1;
        finish_run();
    end
endmodule